// File: doc/BRIEF.md
# Indexed Host Register Port

This block is the host-facing register access unit of a display controller. It sits on a 16-bit parallel bus with a separate data/command select line. A write in command phase selects one of 256 byte-wide register addresses. Each later data-phase read or write goes to the selected register, and the address then steps forward on its own. A host can therefore fill a run of neighbouring registers after sending one address.

Three addresses are streaming ports. At these addresses the selected address stays where it is, so the host can push or pull long runs through one location:
- the pixel memory port at 0x90,
- the filter-coefficient data port at 0x5A,
- the gamma-table data port at 0xB8.

Two lookup tables are held here, each reached through an index register and a data register:
- a 32-entry coefficient table. Its index stops at the end of the table.
- a 256-entry gamma table. Its index wraps.

The block also holds a few control and status registers with special write masks and readback rules: a refresh interval split over two registers, a PLL divider, a non-display status register, and an interrupt-pending register that is cleared by writing zeros.

Top module: `hreg_port`

## Requirements
- R1: A write with `bus_cmd` high loads `bus_wdata[7:0]` into the selected address. A read with `bus_cmd` high returns the selected address on `bus_rdata[7:0]` and changes nothing.
- R2: After each data-phase access (`bus_cmd` low) to a non-streaming address, the selected address moves up by 2, modulo 256.
- R3: At addresses 0x90, 0x5A and 0xB8 the selected address stays the same after a data-phase access.
- R4: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. Bits 15:8 are always 0. An unmapped address reads as 0, and a write to it has no visible effect.
- R5: A write to 0x58 sets the coefficient index to bits 4:0 of the written value. Each data-phase access to 0x5A reads or writes the entry at the index, then adds one to the index. Reading 0x58 returns the index.
- R6: Once the coefficient index reaches 32, accesses to 0x5A are ignored, read as 0, and leave the index at 32.
- R7: Address 0xB6 holds an 8-bit gamma index. Each data-phase access to 0xB8 reads or writes the table entry at the index, then adds one to the index, wrapping from 255 to 0.
- R8: A 12-bit refresh interval takes bits 7:0 from writes to 0x18 and bits 11:8 from bits 3:0 of writes to 0x1A. Each write keeps the other half. Its reset value is 0x25C, and the two addresses read back the two halves.
- R9: A write to 0x04 stores bits 5:0 of the value plus one. A read of 0x04 returns the stored value minus one, with bit 7 set. After reset this read gives 0x80.
- R10: Address 0x02 always reads 0x83. Address 0xE8 keeps bits 0, 1, 3 and 4 of a write and always reads with bit 5 set.
- R11: Each bit of `irq_raise` sets the matching pending bit. A write to 0xF6 ANDs the written value into the pending bits. A raise in the same cycle as the write still sets its bit. 0xF6 reads the pending bits, which also drive `irq_pending`.
- R12: After reset, the selected address, both indices, both tables and `bus_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_cmd | input | 1 | High selects command phase, low selects data phase |
| bus_wdata | input | 16 | Write data; address in command phase |
| irq_raise | input | 8 | Sets pending interrupt bits |
| bus_rdata | output | 16 | Registered read data |
| refresh_interval | output | 12 | Assembled refresh interval |
| irq_pending | output | 8 | Pending interrupt bits |

## Verification
The checker treats one strobe-high cycle as exactly one access, and it assumes that `bus_wr` and `bus_rd` are never raised together. If they were, the write would win. It also assumes that `irq_raise` is quiet in any cycle where it checks that a write to 0xF6 only clears bits. The bench changes every input on the falling edge, raises a single strobe for one cycle per access, and only raises interrupt bits with a separate pulse, except for one deliberate same-cycle case that the pending-bit property excludes.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

   // Addresses whose position is behaviour: the host and the neighbouring
   // blocks decode them, so they are fixed here.
   localparam logic [7:0] ADR_CONFIG  = 8'h02;
   localparam logic [7:0] ADR_PLL     = 8'h04;
   localparam logic [7:0] ADR_REF_LO  = 8'h18;
   localparam logic [7:0] ADR_REF_HI  = 8'h1A;
   localparam logic [7:0] ADR_CF_IDX  = 8'h58;
   localparam logic [7:0] ADR_CF_DAT  = 8'h5A;
   localparam logic [7:0] ADR_PIXEL   = 8'h90;
   localparam logic [7:0] ADR_GM_IDX  = 8'hB6;
   localparam logic [7:0] ADR_GM_DAT  = 8'hB8;
   localparam logic [7:0] ADR_NDSTAT  = 8'hE8;
   localparam logic [7:0] ADR_IRQ     = 8'hF6;

   localparam logic [7:0] CONFIG_WORD  = 8'h83;
   localparam logic [7:0] NDSTAT_KEEP  = 8'h1B;
   localparam logic [7:0] NDSTAT_FORCE = 8'h20;

   // Decoded bus operation for one cycle.
   typedef struct packed {
      logic cmd_wr;
      logic cmd_rd;
      logic dat_wr;
      logic dat_rd;
   } hreg_op_t;

   function automatic logic is_stream(input logic [7:0] a);
      return (a == ADR_PIXEL) || (a == ADR_CF_DAT) || (a == ADR_GM_DAT);
   endfunction

endpackage

// File: rtl/hreg_addr_seq.sv
module hreg_addr_seq
   import hreg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int STEP   = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  hreg_op_t          op,
   input  logic [ADDR_W-1:0] cmd_addr,
   output logic [ADDR_W-1:0] cur_addr
);

   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   if (ADDR_W != 8) begin : g_bad_width
      $error("hreg_addr_seq: address constants assume ADDR_W of 8");
   end
   if (STEP < 1 || STEP >= (1 << ADDR_W)) begin : g_bad_step
      $error("hreg_addr_seq: STEP out of range");
   end

   logic data_access;
   logic hold;

   assign data_access = op.dat_wr | op.dat_rd;
   assign hold        = is_stream(cur_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
      end else if (op.cmd_wr) begin
         cur_addr <= cmd_addr;
      end else if (data_access && !hold) begin
         cur_addr <= cur_addr + STEP_V;
      end
   end

endmodule

// File: rtl/hreg_index_table.sv
module hreg_index_table #(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 8,
   parameter bit WRAP   = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_wr,
   input  logic              dat_wr,
   input  logic              dat_rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] idx_val,
   output logic [DATA_W-1:0] dat_val
);

   localparam int IW = $clog2(DEPTH);
   localparam int CW = WRAP ? IW : IW + 1;

   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("hreg_index_table: DEPTH must be a power of two");
   end
   if (CW > DATA_W || IW > DATA_W) begin : g_bad_width
      $error("hreg_index_table: index does not fit the data width");
   end

   logic [CW-1:0]     cnt;
   logic [IW-1:0]     slot;
   logic              live;
   logic              step;
   logic [DATA_W-1:0] mem [DEPTH];

   assign slot = cnt[IW-1:0];

   if (WRAP) begin : g_wrap
      assign live = 1'b1;
   end else begin : g_stop
      // The counter saturates exactly at DEPTH, so its top bit marks the end.
      assign live = ~cnt[IW];
   end

   assign step = (dat_wr | dat_rd) & live;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (idx_wr) begin
         cnt <= CW'(wdata[IW-1:0]);
      end else if (step) begin
         cnt <= cnt + CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= '0;
         end
      end else if (dat_wr && live) begin
         mem[slot] <= wdata;
      end
   end

   assign idx_val = DATA_W'(cnt);
   assign dat_val = live ? mem[slot] : '0;

endmodule

// File: rtl/hreg_ctrl_file.sv
module hreg_ctrl_file
   import hreg_pkg::*;
#(
   parameter int          DATA_W  = 8,
   parameter int          REF_W   = 12,
   parameter logic [11:0] REF_RST = 12'h25C,
   parameter int          PLL_W   = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] irq_raise,
   output logic [DATA_W-1:0] rd_val,
   output logic [REF_W-1:0]  refresh_q,
   output logic [DATA_W-1:0] irq_pend
);

   localparam int HI_W = REF_W - DATA_W;

   if (DATA_W != 8) begin : g_bad_data
      $error("hreg_ctrl_file: constant words assume DATA_W of 8");
   end
   if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_ref
      $error("hreg_ctrl_file: REF_W must span two data words");
   end
   if (PLL_W < 1 || PLL_W >= DATA_W) begin : g_bad_pll
      $error("hreg_ctrl_file: PLL_W must leave room for the flag bit");
   end

   logic [PLL_W:0]      pll_q;
   logic [DATA_W-1:0]   nd_q;
   logic [PLL_W:0]      pll_less;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pll_q     <= (PLL_W+1)'(1);
         refresh_q <= REF_W'(REF_RST);
         nd_q      <= '0;
         irq_pend  <= '0;
      end else begin
         if (wr_en) begin
            case (addr)
               ADR_PLL:    pll_q <= {1'b0, wdata[PLL_W-1:0]} + (PLL_W+1)'(1);
               ADR_REF_LO: refresh_q[DATA_W-1:0] <= wdata;
               ADR_REF_HI: refresh_q[REF_W-1:DATA_W] <= wdata[HI_W-1:0];
               ADR_NDSTAT: nd_q <= wdata & NDSTAT_KEEP;
               default: ;
            endcase
         end
         if (wr_en && addr == ADR_IRQ) begin
            irq_pend <= (irq_pend & wdata) | irq_raise;
         end else begin
            irq_pend <= irq_pend | irq_raise;
         end
      end
   end

   assign pll_less = pll_q - (PLL_W+1)'(1);

   always_comb begin
      case (addr)
         ADR_CONFIG: rd_val = CONFIG_WORD;
         ADR_PLL:    rd_val = DATA_W'(pll_less) | {1'b1, {(DATA_W-1){1'b0}}};
         ADR_REF_LO: rd_val = refresh_q[DATA_W-1:0];
         ADR_REF_HI: rd_val = DATA_W'(refresh_q[REF_W-1:DATA_W]);
         ADR_NDSTAT: rd_val = nd_q | NDSTAT_FORCE;
         ADR_IRQ:    rd_val = irq_pend;
         default:    rd_val = '0;
      endcase
   end

endmodule

// File: rtl/hreg_port.sv
module hreg_port
   import hreg_pkg::*;
#(
   parameter int          BUS_W       = 16,
   parameter int          ADDR_W      = 8,
   parameter int          REG_W       = 8,
   parameter int          COEF_DEPTH  = 32,
   parameter int          GAMMA_DEPTH = 256,
   parameter int          REF_W       = 12,
   parameter logic [11:0] REF_RST     = 12'h25C,
   parameter int          PLL_W       = 6,
   parameter int          ADDR_STEP   = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic             bus_cmd,
   input  logic [BUS_W-1:0] bus_wdata,
   input  logic [REG_W-1:0] irq_raise,
   output logic [BUS_W-1:0] bus_rdata,
   output logic [REF_W-1:0] refresh_interval,
   output logic [REG_W-1:0] irq_pending
);

   if (BUS_W <= REG_W || ADDR_W != REG_W) begin : g_bad_bus
      $error("hreg_port: bus must be wider than a register, address one register wide");
   end

   hreg_op_t          op;
   logic [ADDR_W-1:0] cur_addr;
   logic [REG_W-1:0]  wbyte;
   logic [REG_W-1:0]  coef_idx;
   logic [REG_W-1:0]  coef_dat;
   logic [REG_W-1:0]  gamma_idx;
   logic [REG_W-1:0]  gamma_dat;
   logic [REG_W-1:0]  ctrl_val;
   logic [REG_W-1:0]  rd_mux;
   logic [REG_W-1:0]  rdata_q;
   logic              unused_hi;

   // A write strobe takes precedence if both strobes are raised.
   assign op.cmd_wr = bus_wr & bus_cmd;
   assign op.cmd_rd = bus_rd & bus_cmd & ~bus_wr;
   assign op.dat_wr = bus_wr & ~bus_cmd;
   assign op.dat_rd = bus_rd & ~bus_cmd & ~bus_wr;

   assign wbyte     = bus_wdata[REG_W-1:0];
   assign unused_hi = ^bus_wdata[BUS_W-1:REG_W];

   hreg_addr_seq #(
      .ADDR_W (ADDR_W),
      .STEP   (ADDR_STEP)
   ) addr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .cmd_addr (bus_wdata[ADDR_W-1:0]),
      .cur_addr (cur_addr)
   );

   hreg_index_table #(
      .DEPTH  (COEF_DEPTH),
      .DATA_W (REG_W),
      .WRAP   (1'b0)
   ) coef_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_wr  (op.dat_wr && cur_addr == ADR_CF_IDX),
      .dat_wr  (op.dat_wr && cur_addr == ADR_CF_DAT),
      .dat_rd  (op.dat_rd && cur_addr == ADR_CF_DAT),
      .wdata   (wbyte),
      .idx_val (coef_idx),
      .dat_val (coef_dat)
   );

   hreg_index_table #(
      .DEPTH  (GAMMA_DEPTH),
      .DATA_W (REG_W),
      .WRAP   (1'b1)
   ) gamma_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_wr  (op.dat_wr && cur_addr == ADR_GM_IDX),
      .dat_wr  (op.dat_wr && cur_addr == ADR_GM_DAT),
      .dat_rd  (op.dat_rd && cur_addr == ADR_GM_DAT),
      .wdata   (wbyte),
      .idx_val (gamma_idx),
      .dat_val (gamma_dat)
   );

   hreg_ctrl_file #(
      .DATA_W  (REG_W),
      .REF_W   (REF_W),
      .REF_RST (REF_RST),
      .PLL_W   (PLL_W)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (op.dat_wr),
      .addr      (cur_addr),
      .wdata     (wbyte),
      .irq_raise (irq_raise),
      .rd_val    (ctrl_val),
      .refresh_q (refresh_interval),
      .irq_pend  (irq_pending)
   );

   always_comb begin
      case (cur_addr)
         ADR_CF_IDX: rd_mux = coef_idx;
         ADR_CF_DAT: rd_mux = coef_dat;
         ADR_GM_IDX: rd_mux = gamma_idx;
         ADR_GM_DAT: rd_mux = gamma_dat;
         default:    rd_mux = ctrl_val;
      endcase
   end

   // The mux is sampled on the same edge that advances the table index,
   // so a data-port read returns the entry at the old index.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (op.cmd_rd) begin
         rdata_q <= cur_addr;
      end else if (op.dat_rd) begin
         rdata_q <= rd_mux;
      end
   end

   assign bus_rdata = BUS_W'(rdata_q);

endmodule

// File: rtl/hreg_port_chk.sv
module hreg_port_chk
   import hreg_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        bus_wr,
   input logic        bus_rd,
   input logic        bus_cmd,
   input logic [15:0] bus_wdata,
   input logic [7:0]  irq_raise,
   input logic [15:0] bus_rdata,
   input logic [7:0]  cur_addr,
   input logic [7:0]  coef_idx,
   input logic [7:0]  gamma_idx,
   input logic [11:0] refresh_interval,
   input logic [7:0]  irq_pending
);

   logic data_acc;
   logic any_rd;
   assign data_acc = (bus_wr | bus_rd) & ~bus_cmd;
   assign any_rd   = bus_rd & ~bus_wr;

   assert_cmd_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_cmd) |=> cur_addr == $past(bus_wdata[7:0]));

   assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !is_stream(cur_addr)) |=> cur_addr == $past(cur_addr) + 8'd2);

   assert_stream_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && is_stream(cur_addr)) |=> $stable(cur_addr));

   assert_rdata_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[15:8] == 8'h00);

   assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !any_rd |=> $stable(bus_rdata));

   assert_coef_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      coef_idx <= 8'd32);

   assert_gamma_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && cur_addr == ADR_GM_DAT) |=> gamma_idx == $past(gamma_idx) + 8'd1);

   assert_refresh_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_cmd && cur_addr == ADR_REF_LO)
         |=> refresh_interval[11:8] == $past(refresh_interval[11:8]));

   assert_irq_clear_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_cmd && cur_addr == ADR_IRQ && irq_raise == 8'h00)
         |=> (irq_pending & ~$past(irq_pending)) == 8'h00);

endmodule

bind hreg_port hreg_port_chk chk_i (
   .clk              (clk),
   .rst_n            (rst_n),
   .bus_wr           (bus_wr),
   .bus_rd           (bus_rd),
   .bus_cmd          (bus_cmd),
   .bus_wdata        (bus_wdata),
   .irq_raise        (irq_raise),
   .bus_rdata        (bus_rdata),
   .cur_addr         (cur_addr),
   .coef_idx         (coef_idx),
   .gamma_idx        (gamma_idx),
   .refresh_interval (refresh_interval),
   .irq_pending      (irq_pending)
);

// File: tb/hreg_port_tb.sv
`timescale 1ns/1ps
module hreg_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_cmd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [7:0]  irq_raise = '0;
   logic [15:0] bus_rdata;
   logic [11:0] refresh_interval;
   logic [7:0]  irq_pending;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string cur_req = "R12";

   always #4 clk = ~clk;

   hreg_port dut_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .bus_wr           (bus_wr),
      .bus_rd           (bus_rd),
      .bus_cmd          (bus_cmd),
      .bus_wdata        (bus_wdata),
      .irq_raise        (irq_raise),
      .bus_rdata        (bus_rdata),
      .refresh_interval (refresh_interval),
      .irq_pending      (irq_pending)
   );

   // Behavioural reference model
   int m_addr, m_rdata, m_cidx, m_gidx, m_pll, m_ref, m_nd, m_irq;
   int m_coef [32];
   int m_gamma [256];

   function automatic bit m_stream(int a);
      return a == 'h90 || a == 'h5A || a == 'hB8;
   endfunction

   function automatic int m_read(int a);
      case (a)
         'h02: return 'h83;
         'h04: return (m_pll - 1) | 'h80;
         'h18: return m_ref & 'hFF;
         'h1A: return m_ref >> 8;
         'h58: return m_cidx;
         'h5A: return (m_cidx < 32) ? m_coef[m_cidx] : 0;
         'hB6: return m_gidx;
         'hB8: return m_gamma[m_gidx];
         'hE8: return m_nd | 'h20;
         'hF6: return m_irq;
         default: return 0;
      endcase
   endfunction

   task automatic m_write(int a, int d);
      case (a)
         'h04: m_pll = (d & 'h3F) + 1;
         'h18: m_ref = (m_ref & 'hF00) | d;
         'h1A: m_ref = (m_ref & 'hFF) | ((d & 'hF) << 8);
         'h58: m_cidx = d & 'h1F;
         'h5A: if (m_cidx < 32) begin m_coef[m_cidx] = d; m_cidx++; end
         'hB6: m_gidx = d;
         'hB8: begin m_gamma[m_gidx] = d; m_gidx = (m_gidx + 1) & 'hFF; end
         'hE8: m_nd = d & 'h1B;
         'hF6: m_irq = m_irq & d;
         default: ;
      endcase
   endtask

   task automatic m_read_side(int a);
      if (a == 'h5A && m_cidx < 32) m_cidx++;
      if (a == 'hB8) m_gidx = (m_gidx + 1) & 'hFF;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_addr = 0; m_rdata = 0; m_cidx = 0; m_gidx = 0;
         m_pll = 1; m_ref = 'h25C; m_nd = 0; m_irq = 0;
         foreach (m_coef[i]) m_coef[i] = 0;
         foreach (m_gamma[i]) m_gamma[i] = 0;
      end else begin
         if (bus_wr && bus_cmd) begin
            m_addr = bus_wdata & 'hFF;
         end else if (bus_rd && bus_cmd) begin
            m_rdata = m_addr;
         end else if (bus_wr || bus_rd) begin
            if (bus_wr) m_write(m_addr, bus_wdata & 'hFF);
            else begin
               m_rdata = m_read(m_addr);
               m_read_side(m_addr);
            end
            if (!m_stream(m_addr)) m_addr = (m_addr + 2) & 'hFF;
         end
         m_irq = m_irq | irq_raise;
      end
   end

   // Compare against the model on every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (bus_rdata !== 16'(m_rdata)) begin
            errors++;
            $display("FAIL %s model compare actual=%h expected=%h", cur_req, bus_rdata, 16'(m_rdata));
         end
      end
   end

   task automatic check_now(logic [15:0] exp, string req);
      checks++;
      if (bus_rdata !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, bus_rdata, exp);
      end
   endtask

   task automatic access(bit w, bit c, logic [15:0] d);
      @(negedge clk);
      bus_wr = w; bus_rd = !w; bus_cmd = c; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; bus_cmd = 1'b0;
   endtask

   task automatic cmd_wr(logic [15:0] a);  access(1'b1, 1'b1, a); endtask
   task automatic dwr(logic [15:0] d);     access(1'b1, 1'b0, d); endtask
   task automatic drd_chk(logic [15:0] e, string req);
      cur_req = req; access(1'b0, 1'b0, '0); check_now(e, req);
   endtask
   task automatic cmd_rd_chk(logic [15:0] e, string req);
      cur_req = req; access(1'b0, 1'b1, '0); check_now(e, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R12 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] pick [12] = '{8'h02, 8'h04, 8'h18, 8'h1A, 8'h58, 8'h5A,
                                8'hB6, 8'hB8, 8'hE8, 8'hF6, 8'h90, 8'h20};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_now(16'h0000, "R12");
      cmd_rd_chk(16'h0000, "R12");

      cmd_wr(16'hAB3C);      cmd_rd_chk(16'h003C, "R1");

      cmd_wr(16'h02);        drd_chk(16'h83, "R10");
      drd_chk(16'h80, "R9"); cmd_rd_chk(16'h06, "R2");

      cmd_wr(16'h18);        drd_chk(16'h5C, "R8"); drd_chk(16'h02, "R8");

      cmd_wr(16'h04); dwr(16'h3F); cmd_wr(16'h04); drd_chk(16'hBF, "R9");
      cmd_wr(16'h04); dwr(16'hC5); cmd_wr(16'h04); drd_chk(16'h85, "R9");

      cmd_wr(16'h18); dwr(16'hAB); dwr(16'h1F);
      cmd_wr(16'h18); drd_chk(16'hAB, "R8"); drd_chk(16'h0F, "R8");
      cmd_wr(16'h18); dwr(16'h01); cmd_wr(16'h1A); drd_chk(16'h0F, "R8");

      cmd_wr(16'hFE); drd_chk(16'h00, "R4"); cmd_rd_chk(16'h00, "R2");

      cmd_wr(16'h90); dwr(16'h1); dwr(16'h2); dwr(16'h3); cmd_rd_chk(16'h90, "R3");

      cmd_wr(16'h58); dwr(16'hFE); dwr(16'h11); dwr(16'h22); dwr(16'h33);
      cmd_rd_chk(16'h5A, "R3");
      cmd_wr(16'h58); drd_chk(16'h20, "R6"); drd_chk(16'h00, "R6");
      cmd_wr(16'h58); dwr(16'h1E);
      drd_chk(16'h11, "R5"); drd_chk(16'h22, "R5"); drd_chk(16'h00, "R6");
      cmd_wr(16'h58); drd_chk(16'h20, "R6");

      cmd_wr(16'hB6); dwr(16'hFF); dwr(16'h77); dwr(16'h88);
      cmd_wr(16'hB6); drd_chk(16'h01, "R7");
      cmd_wr(16'hB6); dwr(16'hFF); drd_chk(16'h77, "R7"); drd_chk(16'h88, "R7");
      cmd_rd_chk(16'hB8, "R3");

      cmd_wr(16'hE8); dwr(16'hFF); cmd_wr(16'hE8); drd_chk(16'h3B, "R10");

      @(negedge clk); irq_raise = 8'hF0; @(negedge clk); irq_raise = 8'h00;
      cmd_wr(16'hF6); drd_chk(16'hF0, "R11");
      cmd_wr(16'hF6); dwr(16'h3F); cmd_wr(16'hF6); drd_chk(16'h30, "R11");
      cmd_wr(16'hF6);
      @(negedge clk); bus_wr = 1'b1; bus_cmd = 1'b0; bus_wdata = 16'h0; irq_raise = 8'h01;
      @(negedge clk); bus_wr = 1'b0; irq_raise = 8'h00;
      cmd_wr(16'hF6); drd_chk(16'h01, "R11");

      cmd_wr(16'h20); dwr(16'hFF); cmd_wr(16'h20); drd_chk(16'h00, "R4");

      cur_req = "R2 random";
      for (int n = 0; n < 3000; n++) begin
         int unsigned r = $urandom_range(99);
         if ($urandom_range(19) == 0) begin
            @(negedge clk); irq_raise = 8'($urandom_range(255));
            @(negedge clk); irq_raise = 8'h00;
         end
         if (r < 30)      cmd_wr(16'(pick[$urandom_range(11)]));
         else if (r < 65) dwr(16'($urandom_range(65535)));
         else if (r < 95) access(1'b0, 1'b0, '0);
         else             access(1'b0, 1'b1, '0);
      end

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule